// File: doc/BRIEF.md
# Flash Block Lock Protection Controller

This controller guards the program and erase operations of a flash array that is split into a small number of blocks. Each block keeps one lock bit that survives between operations. A command port takes an operation code and a target block index. The controller runs a lock-bit write immediately. A program or an erase goes ahead only if the target block is unlocked, or if software has set a global lock-override bit. A read-lock-status command returns the stored bit of the addressed block on a response strobe.

The controller does not model the flash cells. Each accepted program, erase or lock-bit write is timed by a fixed busy counter, and the ready flag stays low for that whole window. The override bit is meant for a single use. It clears itself when the ready flag rises after an operation. It also clears on an invalid command, while CPU access mode is off and while the flash is stopped. Software therefore has to set it again before each operation on a locked block.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset, every lock bit reads 1 (unlocked), `unlock_ovr` is 0, `ready` is 1 and `err` is 0.
- R2: Operation code 3 (lock-bit write) is accepted whatever the block state is. When it completes, the target block's lock bit is 0.
- R3: Operation code 4 (read lock status) does not make the controller busy. In the cycle after acceptance, `rd_valid` is 1 and `rd_lock` holds the stored bit of the target block.
- R4: Operation code 1 (program) or code 2 (erase) aimed at a block whose bit is 0 while `unlock_ovr` is 0 is refused. `ready` stays 1 and `err` becomes 1.
- R5: While `unlock_ovr` is 1, a program to a locked block is accepted, and the stored lock bits are left unchanged.
- R6: When an erase completes, the target block's lock bit is 1. This also holds for a locked block that was erased under the override.
- R7: `unlock_ovr` is 0 in the cycle after `ready` rises at the end of an operation. A further locked block is therefore refused until the override is set again.
- R8: An accepted invalid operation code (0, 5, 6 or 7) clears `unlock_ovr` and changes nothing else. While `cpu_mode_en` is 0 or `flash_stop` is 1, `unlock_ovr` is held at 0 and `ovr_wr` has no effect.
- R9: After a program, erase or lock-bit write is accepted, `ready` is 0 for exactly BUSY_CYC cycles. Commands that arrive while `ready` is 0 are ignored.
- R10: `err` stays set until the next accepted valid command. That command clears `err`, unless it is itself a refused program or erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when ready is 1 |
| cmd_op | input | 3 | Operation code: 1 program, 2 erase, 3 lock-bit write, 4 read lock status |
| cmd_blk | input | BLK_W | Target block index |
| ovr_wr | input | 1 | Write strobe for the override bit |
| ovr_wdata | input | 1 | Value written to the override bit |
| cpu_mode_en | input | 1 | CPU access mode enable; 0 forces the override to 0 |
| flash_stop | input | 1 | Flash stop request; 1 forces the override to 0 |
| ready | output | 1 | 1 when ready, 0 while an operation is busy |
| unlock_ovr | output | 1 | Current state of the lock override bit |
| err | output | 1 | Sticky flag for a refused program or erase |
| rd_valid | output | 1 | One-cycle strobe for a lock status response |
| rd_lock | output | 1 | Lock bit returned by a status read |

## Verification
A lock bit with the wrong value stays hidden until a command touches that block. It then shows as a wrong `rd_lock` one cycle after a status read, or as a program or erase that is refused or granted against the rules, which is visible at once on `err` and `ready`. A faulty override bit or busy counter shows up within one operation, as an override that is still set after `ready` rises or as a busy window of the wrong length. Random command streams are replayed against a bench model of the lock bits, the override and the error flag. Directed cases cover commands issued while busy, the force conditions and erasing a locked block under the override.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_LOCK  = 3'd3,
        OP_RDLK  = 3'd4
    } flash_op_e;

    typedef struct packed {
        logic is_prog;
        logic is_erase;
        logic is_lock;
        logic is_rd;
        logic is_bad;
    } cmd_dec_t;

endpackage

// File: rtl/blk_lock_dec.sv
module blk_lock_dec
    import blk_lock_pkg::*;
(
    input  logic [2:0] op,
    output cmd_dec_t   dec
);
    always_comb begin
        dec = '0;
        case (op)
            OP_PROG:  dec.is_prog  = 1'b1;
            OP_ERASE: dec.is_erase = 1'b1;
            OP_LOCK:  dec.is_lock  = 1'b1;
            OP_RDLK:  dec.is_rd    = 1'b1;
            default:  dec.is_bad   = 1'b1;
        endcase
    end
endmodule

// File: rtl/blk_lock_timer.sv
module blk_lock_timer #(
    parameter int BUSY_CYC = 4,
    localparam int CNT_W = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.busy && (tmr_q.cnt == '0);
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(BUSY_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
endmodule

// File: rtl/blk_lock_bits.sv
module blk_lock_bits #(
    parameter int NUM_BLK = 4,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lock_en,
    input  logic               unlock_en,
    input  logic [BLK_W-1:0]   idx,
    output logic [NUM_BLK-1:0] bits
);
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        logic bit_d, bit_q;
        logic hit;

        assign hit = (idx == BLK_W'(g));

        always_comb begin
            bit_d = bit_q;
            if (hit && lock_en)        bit_d = 1'b0;
            else if (hit && unlock_en) bit_d = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b1;
            else        bit_q <= bit_d;
        end

        assign bits[g] = bit_q;
    end
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLK  = 4,
    parameter int BUSY_CYC = 4,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             ovr_wr,
    input  logic             ovr_wdata,
    input  logic             cpu_mode_en,
    input  logic             flash_stop,
    output logic             ready,
    output logic             unlock_ovr,
    output logic             err,
    output logic             rd_valid,
    output logic             rd_lock
);
    typedef struct packed {
        logic             ovr;
        logic             err;
        logic             rd_valid;
        logic             rd_lock;
        logic             erase_op;
        logic             lock_op;
        logic [BLK_W-1:0] blk;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    cmd_dec_t           dec;
    logic               busy, done, start;
    logic               lock_en, unlock_en;
    logic [NUM_BLK-1:0] lock_bits;
    logic               accept, grant_ok;

    blk_lock_dec u_dec (.op(cmd_op), .dec(dec));

    blk_lock_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    blk_lock_bits #(.NUM_BLK(NUM_BLK)) u_bits (
        .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .unlock_en(unlock_en),
        .idx(ctl_q.blk), .bits(lock_bits)
    );

    assign accept   = cmd_valid && !busy;
    assign grant_ok = lock_bits[cmd_blk] || ctl_q.ovr;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        start          = 1'b0;
        lock_en        = 1'b0;
        unlock_en      = 1'b0;

        if (ovr_wr) ctl_d.ovr = ovr_wdata;

        if (accept) begin
            if (dec.is_bad) begin
                ctl_d.ovr = 1'b0;
            end else begin
                ctl_d.err = 1'b0;
                if (dec.is_rd) begin
                    ctl_d.rd_valid = 1'b1;
                    ctl_d.rd_lock  = lock_bits[cmd_blk];
                end else if (dec.is_lock || grant_ok) begin
                    start          = 1'b1;
                    ctl_d.blk      = cmd_blk;
                    ctl_d.erase_op = dec.is_erase;
                    ctl_d.lock_op  = dec.is_lock;
                end else begin
                    ctl_d.err = 1'b1;
                end
            end
        end

        if (done) begin
            ctl_d.ovr = 1'b0;
            lock_en   = ctl_q.lock_op;
            unlock_en = ctl_q.erase_op;
        end

        if (!cpu_mode_en || flash_stop) ctl_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ready      = !busy;
    assign unlock_ovr = ctl_q.ovr;
    assign err        = ctl_q.err;
    assign rd_valid   = ctl_q.rd_valid;
    assign rd_lock    = ctl_q.rd_lock;
endmodule

// File: rtl/blk_lock_ctrl_chk.sv
module blk_lock_ctrl_chk
    import blk_lock_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       cpu_mode_en,
    input logic       flash_stop,
    input logic       ready,
    input logic       unlock_ovr,
    input logic       err,
    input logic       rd_valid
);
    logic [15:0] low_cnt;
    logic        op_bad;

    assign op_bad = !(cmd_op inside {OP_PROG, OP_ERASE, OP_LOCK, OP_RDLK});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_cnt <= '0;
        else if (ready) low_cnt <= '0;
        else            low_cnt <= low_cnt + 1'b1;
    end

    // R7: the override is gone once ready rises
    p_ovr_clr_on_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !unlock_ovr);

    // R8: force conditions clear the override at the next edge
    p_force_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_mode_en || flash_stop) |=> !unlock_ovr);

    // R8: an accepted invalid code clears the override
    p_bad_cmd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ready && op_bad) |=> !unlock_ovr);

    // R4: a refusal never enters busy
    p_refuse_no_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ready);

    // R3: a status read response appears while ready
    p_read_no_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ready);

    // R9: busy window length
    p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt == 16'(BUSY_CYC)));
endmodule

bind blk_lock_ctrl blk_lock_ctrl_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (.*);

// File: tb/blk_lock_ctrl_bench.sv
module blk_lock_ctrl_bench;
    localparam int NUM_BLK  = 4;
    localparam int BUSY_CYC = 4;
    localparam int BLK_W    = $clog2(NUM_BLK);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [BLK_W-1:0] cmd_blk = '0;
    logic             ovr_wr = 1'b0;
    logic             ovr_wdata = 1'b0;
    logic             cpu_mode_en = 1'b1;
    logic             flash_stop = 1'b0;
    logic             ready, unlock_ovr, err, rd_valid, rd_lock;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  all_done = 1'b0;

    bit  m_lock [NUM_BLK];
    bit  m_ovr;
    bit  m_err;

    always #5 clk = ~clk;

    blk_lock_ctrl #(.NUM_BLK(NUM_BLK), .BUSY_CYC(BUSY_CYC)) u_blk_lock_ctrl (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_valid_op(input int op);
        return (op >= 1) && (op <= 4);
    endfunction

    function automatic bit will_run(input int op, input int blk);
        if (op == 3) return 1'b1;
        if (op == 1 || op == 2) return m_lock[blk] || m_ovr;
        return 1'b0;
    endfunction

    task automatic set_ovr(input bit v);
        @(negedge clk);
        ovr_wr = 1'b1; ovr_wdata = v;
        @(negedge clk);
        ovr_wr = 1'b0;
        m_ovr = v && cpu_mode_en && !flash_stop;
        chk(unlock_ovr == m_ovr, "R8 override write", unlock_ovr, m_ovr);
    endtask

    task automatic exec(input int op, input int blk, input bit stray);
        bit run;
        run = will_run(op, blk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_blk = BLK_W'(blk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!is_valid_op(op)) begin
            m_ovr = 1'b0;
            chk(unlock_ovr == 1'b0, "R8 invalid clears override", unlock_ovr, 0);
            chk(ready == 1'b1, "R8 invalid stays ready", ready, 1);
            chk(err == m_err, "R8 invalid keeps err", err, m_err);
        end else if (op == 4) begin
            m_err = 1'b0;
            chk(rd_valid == 1'b1, "R3 rd_valid", rd_valid, 1);
            chk(rd_lock == m_lock[blk], "R3 rd_lock", rd_lock, m_lock[blk]);
            chk(ready == 1'b1, "R3 read stays ready", ready, 1);
            chk(err == 1'b0, "R10 err cleared", err, 0);
        end else if (!run) begin
            m_err = 1'b1;
            chk(err == 1'b1, "R4 refused sets err", err, 1);
            chk(ready == 1'b1, "R4 refused stays ready", ready, 1);
        end else begin
            m_err = 1'b0;
            chk(ready == 1'b0, "R9 busy after accept", ready, 0);
            chk(err == 1'b0, "R10 err cleared by accepted", err, 0);
            for (int i = 0; i < BUSY_CYC - 1; i++) begin
                if (stray && i == 0) begin
                    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_blk = BLK_W'(blk ^ 1);
                end
                @(negedge clk);
                cmd_valid = 1'b0;
                chk(ready == 1'b0, "R9 busy window", ready, 0);
            end
            @(negedge clk);
            chk(ready == 1'b1, "R9 ready after window", ready, 1);
            m_ovr = 1'b0;
            chk(unlock_ovr == 1'b0, "R7 override cleared at ready", unlock_ovr, 0);
            if (op == 2) m_lock[blk] = 1'b1;
            if (op == 3) m_lock[blk] = 1'b0;
        end
    endtask

    task automatic read_all(input string req);
        for (int b = 0; b < NUM_BLK; b++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'd4; cmd_blk = BLK_W'(b);
            @(negedge clk);
            cmd_valid = 1'b0;
            m_err = 1'b0;
            chk(rd_lock == m_lock[b], req, rd_lock, m_lock[b]);
        end
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        for (int b = 0; b < NUM_BLK; b++) m_lock[b] = 1'b1;
        m_ovr = 1'b0; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(unlock_ovr == 1'b0, "R1 override", unlock_ovr, 0);
        chk(err == 1'b0, "R1 err", err, 0);
        read_all("R1 lock bits unlocked");

        // R2 lock-bit write, R3 readback
        exec(3, 1, 1'b0);
        exec(4, 1, 1'b0);
        // R4 refusal, R10 sticky err
        exec(1, 1, 1'b0);
        exec(0, 2, 1'b0);
        chk(err == 1'b1, "R10 err sticky over invalid", err, 1);
        exec(2, 1, 1'b0);
        exec(2, 0, 1'b0);
        chk(err == 1'b0, "R10 err cleared", err, 0);
        // R5 program under override leaves bits
        exec(3, 2, 1'b0);
        set_ovr(1'b1);
        exec(1, 2, 1'b0);
        read_all("R5 bits unchanged by program");
        // R7 one-shot override
        exec(1, 2, 1'b0);
        chk(err == 1'b1, "R7 second locked op refused", err, 1);
        // R6 erase of locked block under override
        set_ovr(1'b1);
        exec(2, 1, 1'b0);
        exec(4, 1, 1'b0);
        chk(rd_lock == 1'b1, "R6 erased block unlocked", rd_lock, 1);
        // R8 force conditions
        set_ovr(1'b1);
        @(negedge clk); flash_stop = 1'b1;
        @(negedge clk);
        chk(unlock_ovr == 1'b0, "R8 flash_stop clears", unlock_ovr, 0);
        set_ovr(1'b1);
        @(negedge clk); flash_stop = 1'b0; cpu_mode_en = 1'b0;
        set_ovr(1'b1);
        @(negedge clk); cpu_mode_en = 1'b1;
        set_ovr(1'b1);
        exec(6, 0, 1'b0);
        // R9 stray command while busy is ignored
        exec(3, 0, 1'b0);
        exec(3, 3, 1'b1);
        read_all("R9 busy command ignored");

        // random phase
        for (int it = 0; it < 200; it++) begin
            int op, blk;
            if ($urandom % 3 == 0) set_ovr(1'b1);
            op  = int'($urandom % 8);
            blk = int'($urandom % NUM_BLK);
            exec(op, blk, ($urandom % 4) == 0);
        end
        read_all("R2 R6 random final bits");

        all_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule